// File: doc/BRIEF.md
# Reset Sequence Manager

This block decides when the processor core of a small 8-bit controller may run. It collects four reset requests: the external active-low reset pad, a low-voltage flag, a watchdog timeout and an illegal-instruction flag. It then runs a fixed sequence of three phases. The first phase lasts as long as any request is present. The second is a stabilization wait of 256 or 4096 clock cycles, picked by a configuration bit, so that the oscillator can settle. The third is a two-cycle fetch of the reset vector. During the first two phases the block pulls the shared reset pad low through an open-drain enable and holds the core in reset. In the fetch phase it releases the core and presents the two vector byte addresses, high address byte first at FFFEh and then FFFFh.

A pad pulse counts only if it stays low long enough. Its level is pulled into the clock domain by a two-stage synchronizer. A low level clears that synchronizer at once, and a high level is released into it only on clock edges. A one-hot cause register records which request started the most recent sequence. Software can clear it. The input `rst_pin_i` carries the level that external circuitry drives on the pad, not the block's own drive.

Top module: `reset_seq_mgr`

## Requirements
- R1: While `por_n` is low: `rst_pin_oe_o`=1, `cpu_rst_n_o`=0, `vec_fetch_o`=0, `vec_addr_o`=0 and `cause_o`=0.
- R2: The pad request is accepted only if `rst_pin_i` is low across at least MIN_EXT_LOW rising edges (default 4). A pulse of 3 edges leaves the outputs and `cause_o` unchanged. An accepted 4-edge pulse starts the active phase.
- R3: A high level on `lvd_req_i`, `wdg_req_i` or `illop_req_i` enters the active phase at the next rising edge (`rst_pin_oe_o`=1, `cpu_rst_n_o`=0). The phase holds while any request stays high.
- R4: After the last request drops, the delay phase keeps `rst_pin_oe_o`=1 and `cpu_rst_n_o`=0 for exactly 256 cycles when `long_delay_i`=0, or 4096 cycles when it is 1.
- R5: The fetch phase follows the delay. It lasts two cycles with `vec_fetch_o`=1, `cpu_rst_n_o`=1 and `rst_pin_oe_o`=0. `vec_addr_o` is FFFEh in the first cycle and FFFFh in the second. After that the block runs with `vec_fetch_o`=0 and `vec_addr_o`=0.
- R6: A request during the delay or fetch phase returns the block to the active phase at the next edge. The full delay then starts again.
- R7: A request seen outside the active phase loads `cause_o` one-hot: bit0 pad, bit1 low voltage, bit2 watchdog, bit3 illegal instruction. When several requests arrive together, the lowest bit wins. Requests that arrive during the active phase leave `cause_o` unchanged.
- R8: `cause_clr_i` clears `cause_o` at the next edge. A capture in the same cycle wins over the clear.
- R9: When `por_n` is released with no request present, the block goes through the delay and fetch phases into run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | Level driven on the reset pad from outside |
| lvd_req_i | input | 1 | Low-voltage reset request |
| wdg_req_i | input | 1 | Watchdog reset request |
| illop_req_i | input | 1 | Illegal-instruction reset request |
| long_delay_i | input | 1 | 1 selects the 4096-cycle wait, 0 selects 256 |
| cause_clr_i | input | 1 | Clears the cause register |
| rst_pin_oe_o | output | 1 | Open-drain enable that pulls the pad low |
| cpu_rst_n_o | output | 1 | Core reset, active low |
| vec_fetch_o | output | 1 | High during the two fetch cycles |
| vec_addr_o | output | 16 | Vector byte address during the fetch |
| cause_o | output | 4 | One-hot cause of the last sequence |

## Verification
A table of request patterns covers each internal source alone and combined, with hold times from one to five cycles and both delay settings. These patterns separate the priority order of the cause register from the way the active phase stretches with the request. Directed cases test the sequence after power-on, pad pulses one cycle short of and exactly at the minimum width, and restarts from the middle of the delay and from the first fetch cycle, which must both repeat the full wait. Two further cases check that a request arriving in the active phase does not change the cause, and that a capture wins over a clear in the same cycle.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_DELAY  = 3'd1,
    ST_FETCH0 = 3'd2,
    ST_FETCH1 = 3'd3,
    ST_RUN    = 3'd4
  } rsm_state_e;

  // request vector bit positions; lower index has priority in the cause register
  localparam int SRC_N   = 4;
  localparam int SRC_EXT = 0;
  localparam int SRC_LVD = 1;
  localparam int SRC_WDG = 2;
  localparam int SRC_ILL = 3;
endpackage

// File: rtl/rsm_pin_filter.sv
module rsm_pin_filter #(
  parameter int MIN_LOW     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_i,
  output logic ext_req_o
);
  // a pulse held low for MIN_LOW edges is seen low by the synchronizer for MIN_LOW+SYNC_STAGES edges
  localparam int LIM = MIN_LOW + SYNC_STAGES;
  localparam int CW  = $clog2(LIM + 1);

  logic                   arst_n;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_low;
  logic [CW-1:0]          low_cnt_q, low_cnt_d;

  assign arst_n = por_n & pin_i;

  // low level clears the chain at once; release is shifted in on clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign seen_low = ~sync_q[SYNC_STAGES-1];

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (!seen_low)                  low_cnt_d = '0;
    else if (low_cnt_q != CW'(LIM)) low_cnt_d = low_cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) low_cnt_q <= '0;
    else        low_cnt_q <= low_cnt_d;
  end

  assign ext_req_o = (low_cnt_q == CW'(LIM));

  AST_PAD_RELEASE_DROPS: assert property (@(posedge clk) disable iff (!por_n)
    !seen_low |=> !ext_req_o); // R2
endmodule

// File: rtl/rsm_delay_cnt.sv
module rsm_delay_cnt #(
  parameter int SHORT_CYC = 256,
  parameter int LONG_CYC  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  input  logic long_i,
  output logic done_o
);
  localparam int CW = $clog2(LONG_CYC);

  logic [CW-1:0] cnt_q, cnt_d, term;

  assign term   = long_i ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
  assign done_o = (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (en_i && !done_o) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DELAY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/rsm_cause_reg.sv
module rsm_cause_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [N-1:0] req_i,
  input  logic         clr_i,
  output logic [N-1:0] cause_o
);
  logic [N-1:0] pick, cause_d;

  // isolate the lowest set request bit
  assign pick = req_i & (~req_i + N'(1));

  always_comb begin
    cause_d = cause_o;
    if (cap_i && (|req_i)) cause_d = pick;
    else if (clr_i)        cause_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_o <= '0;
    else        cause_o <= cause_d;
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_o)); // R7
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cap_i) |=> (cause_o == '0)); // R8
endmodule

// File: rtl/reset_seq_mgr.sv
module reset_seq_mgr #(
  parameter int              MIN_EXT_LOW = 4,
  parameter int              DLY_SHORT   = 256,
  parameter int              DLY_LONG    = 4096,
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_i,
  input  logic              lvd_req_i,
  input  logic              wdg_req_i,
  input  logic              illop_req_i,
  input  logic              long_delay_i,
  input  logic              cause_clr_i,
  output logic              rst_pin_oe_o,
  output logic              cpu_rst_n_o,
  output logic              vec_fetch_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [3:0]        cause_o
);
  import rsm_pkg::*;

  localparam logic [ADDR_W-1:0] VEC_ADDR_HI = VEC_ADDR + ADDR_W'(1);

  rsm_state_e       state_q, state_d;
  logic             ext_req, req_any, dly_done;
  logic [SRC_N-1:0] req_vec;

  rsm_pin_filter #(.MIN_LOW(MIN_EXT_LOW), .SYNC_STAGES(2)) u_pin (
    .clk       (clk),
    .por_n     (por_n),
    .pin_i     (rst_pin_i),
    .ext_req_o (ext_req)
  );

  always_comb begin
    req_vec          = '0;
    req_vec[SRC_EXT] = ext_req;
    req_vec[SRC_LVD] = lvd_req_i;
    req_vec[SRC_WDG] = wdg_req_i;
    req_vec[SRC_ILL] = illop_req_i;
  end
  assign req_any = |req_vec;

  rsm_delay_cnt #(.SHORT_CYC(DLY_SHORT), .LONG_CYC(DLY_LONG)) u_dly (
    .clk    (clk),
    .rst_n  (por_n),
    .clr_i  (state_q != ST_DELAY),
    .en_i   (state_q == ST_DELAY),
    .long_i (long_delay_i),
    .done_o (dly_done)
  );

  rsm_cause_reg #(.N(SRC_N)) u_cause (
    .clk     (clk),
    .rst_n   (por_n),
    .cap_i   (state_q != ST_ACTIVE),
    .req_i   (req_vec),
    .clr_i   (cause_clr_i),
    .cause_o (cause_o)
  );

  // next-state process
  always_comb begin
    state_d = state_q;
    if (req_any) begin
      state_d = ST_ACTIVE;
    end else begin
      case (state_q)
        ST_ACTIVE: state_d = ST_DELAY;
        ST_DELAY:  if (dly_done) state_d = ST_FETCH0;
        ST_FETCH0: state_d = ST_FETCH1;
        ST_FETCH1: state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_ACTIVE;
      endcase
    end
  end

  // state register
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  // output decode
  always_comb begin
    rst_pin_oe_o = (state_q == ST_ACTIVE) || (state_q == ST_DELAY);
    cpu_rst_n_o  = !rst_pin_oe_o;
    vec_fetch_o  = (state_q == ST_FETCH0) || (state_q == ST_FETCH1);
    vec_addr_o   = '0;
    if (state_q == ST_FETCH0) vec_addr_o = VEC_ADDR;
    if (state_q == ST_FETCH1) vec_addr_o = VEC_ADDR_HI;
  end

  AST_REQ_FORCES_RESET: assert property (@(posedge clk) disable iff (!por_n)
    req_any |=> (rst_pin_oe_o && !cpu_rst_n_o)); // R3
  AST_FETCH_SECOND_BYTE: assert property (@(posedge clk) disable iff (!por_n)
    (vec_fetch_o && (vec_addr_o == VEC_ADDR) && !req_any) |=> (vec_fetch_o && (vec_addr_o == VEC_ADDR_HI))); // R5
  AST_RELEASE_AT_FETCH: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_rst_n_o) |-> (vec_fetch_o && (vec_addr_o == VEC_ADDR))); // R5
  AST_DELAY_TO_FETCH: assert property (@(posedge clk) disable iff (!por_n)
    ((state_q == ST_DELAY) && !req_any && !dly_done) |=> (state_q == ST_DELAY)); // R4
endmodule

// File: tb/tb_reset_seq_mgr.sv
`timescale 1ns/1ps
module tb_reset_seq_mgr;
  logic        clk = 1'b0;
  logic        por_n, rst_pin_i, lvd_req_i, wdg_req_i, illop_req_i, long_delay_i, cause_clr_i;
  logic        rst_pin_oe_o, cpu_rst_n_o, vec_fetch_o;
  logic [15:0] vec_addr_o;
  logic [3:0]  cause_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done_flag = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  reset_seq_mgr dut (
    .clk(clk), .por_n(por_n), .rst_pin_i(rst_pin_i), .lvd_req_i(lvd_req_i),
    .wdg_req_i(wdg_req_i), .illop_req_i(illop_req_i), .long_delay_i(long_delay_i),
    .cause_clr_i(cause_clr_i), .rst_pin_oe_o(rst_pin_oe_o), .cpu_rst_n_o(cpu_rst_n_o),
    .vec_fetch_o(vec_fetch_o), .vec_addr_o(vec_addr_o), .cause_o(cause_o)
  );

  // table: [11] lvd [10] wdg [9] illop [8:5] hold cycles [4] long delay [3:0] expected cause
  localparam int NV = 6;
  localparam logic [11:0] VTBL [NV] = '{
    {3'b100, 4'd1, 1'b0, 4'h2},
    {3'b010, 4'd3, 1'b0, 4'h4},
    {3'b001, 4'd2, 1'b1, 4'h8},
    {3'b111, 4'd1, 1'b0, 4'h2},
    {3'b011, 4'd4, 1'b0, 4'h4},
    {3'b100, 4'd5, 1'b1, 4'h2}
  };

  function automatic logic [31:0] obs();
    return {13'd0, rst_pin_oe_o, cpu_rst_n_o, vec_fetch_o, vec_addr_o};
  endfunction

  function automatic logic [31:0] expo(bit oe, bit rn, bit f, logic [15:0] a);
    return {13'd0, oe, rn, f, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // called on the negedge right after the last request was removed
  task automatic tail(input bit long_sel, input string tag);
    int d;
    d = long_sel ? 4096 : 256;
    repeat (d) @(negedge clk);
    chk({tag, " R4 delay end"}, obs(), expo(1, 0, 0, 16'h0));
    @(negedge clk);
    chk({tag, " R5 fetch FFFE"}, obs(), expo(0, 1, 1, 16'hFFFE));
    @(negedge clk);
    chk({tag, " R5 fetch FFFF"}, obs(), expo(0, 1, 1, 16'hFFFF));
    @(negedge clk);
    chk({tag, " R5 run"}, obs(), expo(0, 1, 0, 16'h0));
  endtask

  task automatic clear_cause();
    cause_clr_i = 1'b1;
    @(negedge clk);
    cause_clr_i = 1'b0;
    chk("R8 clear", {28'd0, cause_o}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    bit seen;
    por_n = 1'b0; rst_pin_i = 1'b1; lvd_req_i = 1'b0; wdg_req_i = 1'b0;
    illop_req_i = 1'b0; long_delay_i = 1'b0; cause_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", obs(), expo(1, 0, 0, 16'h0));
    chk("R1 cause in reset", {28'd0, cause_o}, 32'h0);
    por_n = 1'b1;
    tail(1'b0, "R9");

    // table walk
    for (int i = 0; i < NV; i++) begin
      clear_cause();
      {lvd_req_i, wdg_req_i, illop_req_i} = VTBL[i][11:9];
      long_delay_i = VTBL[i][4];
      @(negedge clk);
      chk("R3 enter active", obs(), expo(1, 0, 0, 16'h0));
      chk("R7 cause", {28'd0, cause_o}, {28'd0, VTBL[i][3:0]});
      repeat (int'(VTBL[i][8:5]) - 1) @(negedge clk);
      chk("R3 active held", obs(), expo(1, 0, 0, 16'h0));
      {lvd_req_i, wdg_req_i, illop_req_i} = 3'b000;
      tail(VTBL[i][4], "R4");
      long_delay_i = 1'b0;
    end

    // pad pulse one edge too short
    clear_cause();
    rst_pin_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_pin_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 short pulse outputs", obs(), expo(0, 1, 0, 16'h0));
    chk("R2 short pulse cause", {28'd0, cause_o}, 32'h0);

    // pad pulse of exactly the minimum width
    rst_pin_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_pin_i = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (rst_pin_oe_o) begin seen = 1'b1; break; end
    end
    chk("R2 min pulse accepted", {31'd0, seen}, 32'h1);
    chk("R7 pad cause", {28'd0, cause_o}, 32'h1);
    tail(1'b0, "R2");

    // restart from the middle of the delay
    lvd_req_i = 1'b1;
    @(negedge clk);
    lvd_req_i = 1'b0;
    repeat (100) @(negedge clk);
    wdg_req_i = 1'b1;
    @(negedge clk);
    chk("R6 restart in delay", obs(), expo(1, 0, 0, 16'h0));
    chk("R7 cause overwritten", {28'd0, cause_o}, 32'h4);
    wdg_req_i = 1'b0;
    tail(1'b0, "R6");

    // restart from the first fetch cycle
    lvd_req_i = 1'b1;
    @(negedge clk);
    lvd_req_i = 1'b0;
    repeat (257) @(negedge clk);
    chk("R5 first fetch", obs(), expo(0, 1, 1, 16'hFFFE));
    illop_req_i = 1'b1;
    @(negedge clk);
    chk("R6 restart in fetch", obs(), expo(1, 0, 0, 16'h0));
    chk("R6 cause illop", {28'd0, cause_o}, 32'h8);
    illop_req_i = 1'b0;
    tail(1'b0, "R6");

    // requests during the active phase leave the cause alone
    clear_cause();
    lvd_req_i = 1'b1;
    @(negedge clk);
    chk("R7 first cause", {28'd0, cause_o}, 32'h2);
    wdg_req_i = 1'b1;
    @(negedge clk);
    chk("R7 active keeps cause", {28'd0, cause_o}, 32'h2);
    lvd_req_i = 1'b0; wdg_req_i = 1'b0;
    tail(1'b0, "R7");

    // capture beats clear
    cause_clr_i = 1'b1; wdg_req_i = 1'b1;
    @(negedge clk);
    chk("R8 capture wins", {28'd0, cause_o}, 32'h4);
    cause_clr_i = 1'b0; wdg_req_i = 1'b0;
    tail(1'b0, "R8");

    done_flag = 1'b1;
    report();
    $finish;
  end
endmodule